// File: doc/BRIEF.md
# UART Autobaud Detector with Acknowledge

This block sits on a UART receive/transmit pin pair during boot and works out the line rate on its own. Once armed, it waits for the host to send the sync character 0xAA. It times that character's edges against the system clock and turns the measured span into a bit-period divisor. It then locks, and from that point the divisor never changes.

Right after locking, an internal sequencer replies on the transmit pin with the two characters 0x4F and 0x4B ("OK"). The reply goes through the same holding register and shift register that software uses later.

A small register port lets software poll a status byte, write the holding register and read received characters. Received characters come from a 16x-oversampled receiver that runs on the locked divisor. The holding-register-empty status bit updates with no lag. Software that polls it therefore cannot overwrite a character that is still waiting.

Top module: `abd_autobaud`

## Requirements
- R1: After reset, `locked_o` is low, `divisor_o` is 0 and `txd_o` is high. The status byte (read with `reg_sel_i`=1) is 0x60: bit 5 = holding register empty, bit 6 = transmitter idle, bit 0 = receive data ready.
- R2: Detection is armed only by a `start_i` pulse while unlocked. A sync character that arrives before any arming does not lock the block.
- R3: The measurement runs from the start-bit falling edge to the fourth rising edge after it, which spans 8 bit periods of 0xAA sent 8N1 with the LSB first. The divisor is that cycle count divided by 8, and `locked_o` then rises.
- R4: If the measurement count reaches `MAX_COUNT` before the fourth rising edge, the attempt is dropped and the detector re-arms by itself. A following valid sync character locks without a new `start_i`.
- R5: A result below `MIN_DIV` is rejected and the detector re-arms by itself.
- R6: Once locked, `locked_o` stays high and `divisor_o` stays frozen. Further `start_i` pulses and line traffic do not change them.
- R7: After lock, the transmitter sends exactly 0x4F and then 0x4B as 8N1 frames, LSB first, each bit lasting `divisor_o` cycles. Before lock, `txd_o` stays high.
- R8: Software writes to the holding register (`reg_sel_i`=0) are dropped until the acknowledge has fully left the transmitter.
- R9: Status bit 5 reads 0 in the cycle after a holding-register write is taken. It returns to 1 once the shift register has taken the byte. Bytes written each time bit 5 reads 1 all leave in order.
- R10: Status bit 6 is 1 only when the holding register is empty and the shift register is idle.
- R11: After lock, a received 8N1 frame sets status bit 0 and its byte reads at `reg_sel_i`=0. A read strobe at `reg_sel_i`=0 clears bit 0.
- R12: A frame whose stop bit is low is discarded (bit 0 stays 0), and the receiver accepts the next good frame.
- R13: The receiver is disabled before lock, so the sync character never sets status bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| rxd_i | input | 1 | Serial receive line, idle high |
| txd_o | output | 1 | Serial transmit line, idle high |
| start_i | input | 1 | Arms baud detection (pulse) |
| locked_o | output | 1 | Divisor measured and frozen |
| divisor_o | output | DIV_W | Bit period in clock cycles |
| reg_sel_i | input | 1 | 0 = data (holding write / receive read), 1 = status |
| reg_wr_i | input | 1 | Write strobe |
| reg_rd_i | input | 1 | Read strobe (clears receive ready at data select) |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, combinational on `reg_sel_i` |

## Verification
A miscounted edge or span in the detector shows up on `divisor_o` as a value off by a factor or by a bit period, in the very cycle `locked_o` rises. A lagging empty flag appears at the status port one cycle after a write, as a bit 5 that still reads 1. A later, tighter poll then loses a character on `txd_o` within one frame. Faults in the receiver's phase or stop check show up when status bit 0 and the data byte are read about half a bit after the stop bit.

// File: rtl/abd_pkg.sv
// Shared constants and state types for the autobaud UART.
package abd_pkg;
    localparam int CHAR_BITS      = 8;
    localparam int SYNC_RISES     = 4;   // rising edges that close the sync span
    localparam int SPAN_LOG2      = 3;   // the span covers 2**3 bit periods
    localparam int ST_RXRDY       = 0;
    localparam int ST_HOLD_EMPTY  = 5;
    localparam int ST_XMIT_IDLE   = 6;
    localparam logic [7:0] ACK_FIRST  = 8'h4F;
    localparam logic [7:0] ACK_SECOND = 8'h4B;

    typedef enum logic [1:0] {MS_IDLE, MS_ARMED, MS_COUNT, MS_LOCKED} meas_state_t;
    typedef enum logic [2:0] {RS_IDLE, RS_START, RS_DATA, RS_STOP, RS_WAIT} rx_state_t;
    typedef enum logic [1:0] {AS_FIRST, AS_SECOND, AS_DRAIN, AS_DONE} ack_state_t;
endpackage

// File: rtl/abd_meas.sv
// Baud measurement. Once armed, it counts clock cycles from a falling edge
// to the fourth rising edge after it (8 bit periods of 0xAA) and locks the
// divisor. It assumes fall_i/rise_i come from a synchronized line, so both
// edges carry the same delay.
module abd_meas
    import abd_pkg::*;
#(
    parameter int DIV_W     = 16,
    parameter int MAX_COUNT = 524287,
    parameter int MIN_DIV   = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             arm_i,
    input  logic             fall_i,
    input  logic             rise_i,
    output logic             locked_o,
    output logic [DIV_W-1:0] divisor_o
);
    localparam int CNT_W = DIV_W + SPAN_LOG2;
    localparam logic [CNT_W-1:0] CNT_LIMIT = CNT_W'(MAX_COUNT);
    localparam logic [DIV_W-1:0] DIV_FLOOR = DIV_W'(MIN_DIV);

    meas_state_t      st;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_nx;
    logic [1:0]       rises;
    logic [DIV_W-1:0] cand;

    assign cnt_nx = cnt + 1'b1;
    assign cand   = cnt_nx[CNT_W-1:SPAN_LOG2];

    // Detection state machine with timeout, floor check and freeze.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st        <= MS_IDLE;
            cnt       <= '0;
            rises     <= '0;
            divisor_o <= '0;
        end else begin
            case (st)
                MS_IDLE: if (arm_i) st <= MS_ARMED;
                MS_ARMED: begin
                    if (fall_i) begin
                        st    <= MS_COUNT;
                        cnt   <= '0;
                        rises <= '0;
                    end
                end
                MS_COUNT: begin
                    cnt <= cnt_nx;
                    if (rise_i) begin
                        if (rises == 2'(SYNC_RISES - 1)) begin
                            if (cand >= DIV_FLOOR) begin
                                divisor_o <= cand;
                                st        <= MS_LOCKED;
                            end else begin
                                st <= MS_ARMED;
                            end
                        end else begin
                            rises <= rises + 1'b1;
                        end
                    end else if (cnt_nx >= CNT_LIMIT) begin
                        st <= MS_ARMED;
                    end
                end
                MS_LOCKED: st <= MS_LOCKED;
                default:   st <= MS_IDLE;
            endcase
        end
    end

    assign locked_o = (st == MS_LOCKED);
endmodule

// File: rtl/abd_tx.sv
// Transmitter: one holding register feeding a 10-bit 8N1 shift register.
// The empty flag is a register that is set full on the write edge itself,
// so a poll in the next cycle already sees it full. Assumes div_i >= 1.
module abd_tx
    import abd_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [DIV_W-1:0] div_i,
    input  logic             wr_i,
    input  logic [7:0]       wdata_i,
    output logic             txd_o,
    output logic             hold_empty_o,
    output logic             idle_o
);
    localparam int FRAME_BITS = CHAR_BITS + 2;
    localparam int BIT_W      = $clog2(FRAME_BITS);

    logic [7:0]            hold_q;
    logic                  hold_full;
    logic [FRAME_BITS-1:0] shreg;
    logic                  busy;
    logic [BIT_W-1:0]      bitcnt;
    logic [DIV_W-1:0]      baud_cnt;
    logic                  load;

    assign load = hold_full & ~busy;

    // Holding register: a write marks it full, a transfer to the shifter empties it.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            hold_full <= 1'b0;
            hold_q    <= '0;
        end else begin
            hold_full <= (hold_full & ~load) | wr_i;
            if (wr_i) hold_q <= wdata_i;
        end
    end

    // Shift register: frames the byte and shifts one bit every div_i cycles.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            shreg    <= '1;
            busy     <= 1'b0;
            bitcnt   <= '0;
            baud_cnt <= '0;
        end else if (load) begin
            shreg    <= {1'b1, hold_q, 1'b0};
            busy     <= 1'b1;
            bitcnt   <= '0;
            baud_cnt <= '0;
        end else if (busy) begin
            if (baud_cnt == div_i - 1'b1) begin
                baud_cnt <= '0;
                shreg    <= {1'b1, shreg[FRAME_BITS-1:1]};
                if (bitcnt == BIT_W'(FRAME_BITS - 1)) busy <= 1'b0;
                else bitcnt <= bitcnt + 1'b1;
            end else begin
                baud_cnt <= baud_cnt + 1'b1;
            end
        end
    end

    assign txd_o        = busy ? shreg[0] : 1'b1;
    assign hold_empty_o = ~hold_full;
    assign idle_o       = ~hold_full & ~busy;
endmodule

// File: rtl/abd_rx.sv
// Receiver with 16x oversampling. A phase accumulator adds 16 per clock and
// ticks when it passes the divisor, giving 16 ticks per bit on average. The
// start bit is checked at tick 8 and each later bit is sampled 16 ticks on.
// A frame with a low stop bit is dropped, and the receiver waits for the
// line to go high. Assumes div_i >= 16.
module abd_rx
    import abd_pkg::*;
#(
    parameter int DIV_W = 16,
    parameter int OVS   = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic             rxd_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             valid_o,
    output logic [7:0]       data_o
);
    localparam int ACC_W  = DIV_W + 1;
    localparam int SUB_W  = $clog2(OVS);
    localparam int BITN_W = $clog2(CHAR_BITS);
    localparam logic [SUB_W-1:0] SUB_MID = SUB_W'(OVS / 2 - 1);
    localparam logic [SUB_W-1:0] SUB_END = SUB_W'(OVS - 1);

    rx_state_t         st;
    logic [ACC_W-1:0]  acc;
    logic [ACC_W-1:0]  acc_sum;
    logic              tick;
    logic [SUB_W-1:0]  sub;
    logic [BITN_W-1:0] bitn;
    logic [7:0]        sh;

    assign acc_sum = acc + ACC_W'(OVS);
    assign tick    = (st != RS_IDLE) && (acc_sum >= {1'b0, div_i});

    // Oversample phase accumulator, restarted at every start-bit detection.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)           acc <= '0;
        else if (st == RS_IDLE) acc <= '0;
        else if (tick)         acc <= acc_sum - {1'b0, div_i};
        else                   acc <= acc_sum;
    end

    // Frame state machine: start check, data sampling, stop check.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st      <= RS_IDLE;
            sub     <= '0;
            bitn    <= '0;
            sh      <= '0;
            valid_o <= 1'b0;
            data_o  <= '0;
        end else begin
            valid_o <= 1'b0;
            case (st)
                RS_IDLE: begin
                    if (en_i && !rxd_i) begin
                        st  <= RS_START;
                        sub <= '0;
                    end
                end
                RS_START: if (tick) begin
                    if (sub == SUB_MID) begin
                        sub  <= '0;
                        bitn <= '0;
                        st   <= rxd_i ? RS_IDLE : RS_DATA;
                    end else sub <= sub + 1'b1;
                end
                RS_DATA: if (tick) begin
                    if (sub == SUB_END) begin
                        sub <= '0;
                        sh  <= {rxd_i, sh[7:1]};
                        if (bitn == BITN_W'(CHAR_BITS - 1)) st <= RS_STOP;
                        else bitn <= bitn + 1'b1;
                    end else sub <= sub + 1'b1;
                end
                RS_STOP: if (tick) begin
                    if (sub == SUB_END) begin
                        sub <= '0;
                        if (rxd_i) begin
                            valid_o <= 1'b1;
                            data_o  <= sh;
                            st      <= RS_IDLE;
                        end else begin
                            st <= RS_WAIT;
                        end
                    end else sub <= sub + 1'b1;
                end
                RS_WAIT: if (rxd_i) st <= RS_IDLE;
                default: st <= RS_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/abd_ack.sv
// Acknowledge sequencer. After lock it writes the first reply character
// when the holding register reads empty, then the second when it reads
// empty again. It reports done once the transmitter has drained. Relies on
// the empty flag being registered, so it cannot write twice into one full slot.
module abd_ack
    import abd_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       locked_i,
    input  logic       hold_empty_i,
    input  logic       xmit_idle_i,
    output logic       wr_o,
    output logic [7:0] wdata_o,
    output logic       done_o
);
    ack_state_t st;

    // Write request and character for the current step.
    always_comb begin
        wr_o    = 1'b0;
        wdata_o = ACK_FIRST;
        case (st)
            AS_FIRST:  wr_o = locked_i & hold_empty_i;
            AS_SECOND: begin
                wr_o    = hold_empty_i;
                wdata_o = ACK_SECOND;
            end
            default: wr_o = 1'b0;
        endcase
    end

    // Step through first char, second char, drain, done.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) st <= AS_FIRST;
        else begin
            case (st)
                AS_FIRST:  if (wr_o) st <= AS_SECOND;
                AS_SECOND: if (wr_o) st <= AS_DRAIN;
                AS_DRAIN:  if (xmit_idle_i) st <= AS_DONE;
                default:   st <= AS_DONE;
            endcase
        end
    end

    assign done_o = (st == AS_DONE);
endmodule

// File: rtl/abd_autobaud.sv
// Top of the autobaud UART. It synchronizes the receive line, measures the
// sync character, sends the acknowledge, and then serves a register port:
// select 0 writes the holding register or reads the received byte, select 1
// reads the status byte. Assumes a single clock domain with rxd_i asynchronous.
module abd_autobaud
    import abd_pkg::*;
#(
    parameter int DIV_W     = 16,
    parameter int MAX_COUNT = 524287,
    parameter int MIN_DIV   = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             rxd_i,
    output logic             txd_o,
    input  logic             start_i,
    output logic             locked_o,
    output logic [DIV_W-1:0] divisor_o,
    input  logic             reg_sel_i,
    input  logic             reg_wr_i,
    input  logic             reg_rd_i,
    input  logic [7:0]       reg_wdata_i,
    output logic [7:0]       reg_rdata_o
);
    logic       rx_meta, rx_sync, rx_prev;
    logic       fall, rise;
    logic       ack_wr, ack_done;
    logic [7:0] ack_data;
    logic       sw_wr, thr_wr;
    logic [7:0] thr_data;
    logic       thr_empty, tx_idle;
    logic       rx_valid;
    logic [7:0] rx_byte;
    logic       rdr;
    logic [7:0] rbr;
    logic [7:0] status;

    // Two-flop synchronizer plus one delay stage for edge detection.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            rx_meta <= 1'b1;
            rx_sync <= 1'b1;
            rx_prev <= 1'b1;
        end else begin
            rx_meta <= rxd_i;
            rx_sync <= rx_meta;
            rx_prev <= rx_sync;
        end
    end

    assign fall = rx_prev & ~rx_sync;
    assign rise = ~rx_prev & rx_sync;

    abd_meas #(.DIV_W(DIV_W), .MAX_COUNT(MAX_COUNT), .MIN_DIV(MIN_DIV)) u_meas (
        .clk_i(clk_i), .rst_ni(rst_ni), .arm_i(start_i), .fall_i(fall),
        .rise_i(rise), .locked_o(locked_o), .divisor_o(divisor_o)
    );

    abd_ack u_ack (
        .clk_i(clk_i), .rst_ni(rst_ni), .locked_i(locked_o),
        .hold_empty_i(thr_empty), .xmit_idle_i(tx_idle),
        .wr_o(ack_wr), .wdata_o(ack_data), .done_o(ack_done)
    );

    assign sw_wr    = reg_wr_i & ~reg_sel_i & ack_done;
    assign thr_wr   = ack_wr | sw_wr;
    assign thr_data = ack_wr ? ack_data : reg_wdata_i;

    abd_tx #(.DIV_W(DIV_W)) u_tx (
        .clk_i(clk_i), .rst_ni(rst_ni), .div_i(divisor_o), .wr_i(thr_wr),
        .wdata_i(thr_data), .txd_o(txd_o), .hold_empty_o(thr_empty), .idle_o(tx_idle)
    );

    abd_rx #(.DIV_W(DIV_W)) u_rx (
        .clk_i(clk_i), .rst_ni(rst_ni), .en_i(locked_o), .rxd_i(rx_sync),
        .div_i(divisor_o), .valid_o(rx_valid), .data_o(rx_byte)
    );

    // Received byte buffer and ready flag; a data-select read clears the flag.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            rdr <= 1'b0;
            rbr <= '0;
        end else if (rx_valid) begin
            rdr <= 1'b1;
            rbr <= rx_byte;
        end else if (reg_rd_i && !reg_sel_i) begin
            rdr <= 1'b0;
        end
    end

    // Status byte assembly.
    always_comb begin
        status                = '0;
        status[ST_RXRDY]      = rdr;
        status[ST_HOLD_EMPTY] = thr_empty;
        status[ST_XMIT_IDLE]  = tx_idle;
    end

    assign reg_rdata_o = reg_sel_i ? status : rbr;
endmodule

// File: rtl/abd_autobaud_chk.sv
// Property checker for abd_autobaud, bound to every instance of the top.
module abd_autobaud_chk #(
    parameter int DIV_W   = 16,
    parameter int MIN_DIV = 16
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             locked_i,
    input logic [DIV_W-1:0] div_i,
    input logic             txd_i,
    input logic             thr_wr_i,
    input logic             hold_empty_i,
    input logic             xmit_idle_i,
    input logic             rx_valid_i
);
    assert_hold_full_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        thr_wr_i |=> !hold_empty_i);

    assert_lock_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        locked_i |=> locked_i);

    assert_div_frozen_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        locked_i |=> $stable(div_i));

    assert_div_floor_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(locked_i) |-> (div_i >= DIV_W'(MIN_DIV)));

    assert_idle_means_empty_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        xmit_idle_i |-> hold_empty_i);

    assert_quiet_before_lock_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !locked_i |-> txd_i);

    assert_rx_after_lock_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rx_valid_i |-> locked_i);
endmodule

bind abd_autobaud abd_autobaud_chk #(.DIV_W(DIV_W), .MIN_DIV(MIN_DIV)) u_chk (
    .clk_i(clk_i), .rst_ni(rst_ni), .locked_i(locked_o), .div_i(divisor_o),
    .txd_i(txd_o), .thr_wr_i(thr_wr), .hold_empty_i(thr_empty),
    .xmit_idle_i(tx_idle), .rx_valid_i(rx_valid)
);

// File: tb/abd_autobaud_bench.sv
module abd_autobaud_bench;
    localparam int DIV_W = 16;
    localparam int P     = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rxd = 1'b1;
    logic txd;
    logic start = 1'b0;
    logic locked;
    logic [DIV_W-1:0] divisor;
    logic reg_sel = 1'b1;
    logic reg_wr = 1'b0;
    logic reg_rd = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    abd_autobaud #(.DIV_W(DIV_W), .MAX_COUNT(2000), .MIN_DIV(16)) u_abd_autobaud (
        .clk_i(clk), .rst_ni(rst_n), .rxd_i(rxd), .txd_o(txd), .start_i(start),
        .locked_o(locked), .divisor_o(divisor), .reg_sel_i(reg_sel),
        .reg_wr_i(reg_wr), .reg_rd_i(reg_rd), .reg_wdata_i(reg_wdata),
        .reg_rdata_o(reg_rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic drive_frame(input logic [7:0] b, input int p, input logic stop_bit);
        @(negedge clk); rxd = 1'b0;
        repeat (p) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            repeat (p) @(negedge clk);
        end
        rxd = stop_bit;
        repeat (p) @(negedge clk);
        rxd = 1'b1;
    endtask

    task automatic capture_tx(output logic [7:0] b, output logic ok, input int p);
        int n = 0;
        ok = 1'b1;
        b = 8'h00;
        while (txd === 1'b1 && n < 20000) begin @(negedge clk); n++; end
        if (n >= 20000) ok = 1'b0;
        repeat (p / 2) @(negedge clk);
        if (txd !== 1'b0) ok = 1'b0;
        for (int i = 0; i < 8; i++) begin
            repeat (p) @(negedge clk);
            b[i] = txd;
        end
        repeat (p) @(negedge clk);
        if (txd !== 1'b1) ok = 1'b0;
    endtask

    task automatic read_status(output logic [7:0] s);
        reg_sel = 1'b1; #1; s = reg_rdata;
    endtask

    task automatic read_data(output logic [7:0] d);
        @(negedge clk); reg_sel = 1'b0; reg_rd = 1'b1; #1; d = reg_rdata;
        @(negedge clk); reg_rd = 1'b0; reg_sel = 1'b1;
    endtask

    task automatic reg_write(input logic [7:0] d);
        @(negedge clk); reg_sel = 1'b0; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0; reg_sel = 1'b1;
    endtask

    task automatic pulse_start;
        @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [7:0] s;
        @(negedge clk); read_status(s);
        check("R1 locked", 32'(locked), 32'd0);
        check("R1 divisor", 32'(divisor), 32'd0);
        check("R1 txd", 32'(txd), 32'd1);
        check("R1 status", 32'(s), 32'h60);
    endtask

    task automatic t_no_start;
        drive_frame(8'hAA, P, 1'b1);
        repeat (20) @(negedge clk);
        check("R2 no lock without arm", 32'(locked), 32'd0);
    endtask

    task automatic t_timeout;
        pulse_start();
        @(negedge clk); rxd = 1'b0;
        repeat (2100) @(negedge clk);
        rxd = 1'b1;
        repeat (50) @(negedge clk);
        check("R4 timeout no lock", 32'(locked), 32'd0);
    endtask

    task automatic t_short;
        drive_frame(8'hAA, 10, 1'b1);
        repeat (20) @(negedge clk);
        check("R5 short divisor rejected", 32'(locked), 32'd0);
    endtask

    task automatic t_lock_ack;
        logic [7:0] b0, b1, s;
        logic ok0, ok1;
        logic got_lock = 1'b0;
        logic stayed_high = 1'b1;
        fork
            drive_frame(8'hAA, P, 1'b1);
            begin
                for (int i = 0; i < 2000 && !locked; i++) @(negedge clk);
                got_lock = locked;
                check("R3 locked after sync (R4 re-arm)", 32'(got_lock), 32'd1);
                check("R3 divisor", 32'(divisor), 32'(P));
                repeat (100) @(negedge clk);
                reg_write(8'h55);
            end
            begin
                capture_tx(b0, ok0, P);
                capture_tx(b1, ok1, P);
            end
        join
        check("R7 first frame ok", 32'(ok0), 32'd1);
        check("R7 first char", 32'(b0), 32'h4F);
        check("R7 second frame ok", 32'(ok1), 32'd1);
        check("R7 second char", 32'(b1), 32'h4B);
        for (int i = 0; i < 15 * P; i++) begin
            @(negedge clk);
            if (txd !== 1'b1) stayed_high = 1'b0;
        end
        check("R8 early write dropped", 32'(stayed_high), 32'd1);
        read_status(s);
        check("R13 sync not received", 32'(s[0]), 32'd0);
        check("R10 idle status", 32'(s), 32'h60);
    endtask

    task automatic t_thr;
        logic [7:0] b0, b1, s;
        logic ok0, ok1;
        int n;
        fork
            begin
                capture_tx(b0, ok0, P);
                capture_tx(b1, ok1, P);
            end
            begin
                reg_write(8'h12);
                read_status(s);
                check("R9 full right after write", 32'(s[5]), 32'd0);
                check("R10 not idle after write", 32'(s[6]), 32'd0);
                n = 0;
                do begin @(negedge clk); read_status(s); n++; end while (!s[5] && n < 10);
                check("R9 empty once shifter loads", 32'(s[5]), 32'd1);
                check("R10 busy shifter not idle", 32'(s[6]), 32'd0);
                reg_write(8'h34);
                read_status(s);
                check("R9 full after second write", 32'(s[5]), 32'd0);
            end
        join
        check("R9 first byte", 32'({ok0, b0}), 32'h112);
        check("R9 second byte in order", 32'({ok1, b1}), 32'h134);
        n = 0;
        do begin @(negedge clk); read_status(s); n++; end while (s != 8'h60 && n < 4 * P);
        check("R10 idle after drain", 32'(s), 32'h60);
    endtask

    task automatic t_rx;
        logic [7:0] s, d;
        drive_frame(8'h3C, P, 1'b1);
        repeat (10) @(negedge clk);
        read_status(s);
        check("R11 ready set", 32'(s[0]), 32'd1);
        read_data(d);
        check("R11 data", 32'(d), 32'h3C);
        read_status(s);
        check("R11 ready cleared by read", 32'(s[0]), 32'd0);
    endtask

    task automatic t_badstop;
        logic [7:0] s, d;
        drive_frame(8'h5A, P, 1'b0);
        repeat (3 * P) @(negedge clk);
        read_status(s);
        check("R12 bad stop dropped", 32'(s[0]), 32'd0);
        drive_frame(8'hC3, P, 1'b1);
        repeat (10) @(negedge clk);
        read_status(s);
        check("R12 recovers ready", 32'(s[0]), 32'd1);
        read_data(d);
        check("R12 recovers data", 32'(d), 32'hC3);
    endtask

    task automatic t_freeze;
        pulse_start();
        drive_frame(8'hAA, 20, 1'b1);
        repeat (50) @(negedge clk);
        check("R6 still locked", 32'(locked), 32'd1);
        check("R6 divisor frozen", 32'(divisor), 32'(P));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog all-requirements actual=timeout expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_no_start();
        t_timeout();
        t_short();
        t_lock_ack();
        t_thr();
        t_rx();
        t_badstop();
        t_freeze();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule